// File: doc/BRIEF.md
# DMA Channel Error Capture Unit

This unit sits next to a multi-channel DMA engine and turns error strobes from the engine into a terminate pulse plus a record of what went wrong. The engine announces each channel service with a start strobe and the channel number. During the service it reports read and write beats, bus errors on those beats, and configuration faults found in the descriptor. The unit also checks the priority setup each time a service starts. Channel priorities must be distinct inside each group, and group priorities must be distinct across groups.

When an error terminates a service, the unit sets that channel's bit in a sticky error bitmap. It loads a status word with one-hot type flags and the channel number, and pulses a stop output so the engine abandons the service. A bus error on the final beat of a read or write phase is not acted on at once. The unit lets the next opposite-direction phase run to its last beat, then terminates. The engine's address and count values from the cycle the error was detected are held in fault snapshot registers.

While a service is known to be failing, completion and interrupt requests from the engine are masked. Channels are never disabled. Software removes bitmap bits through a clear port that takes either one channel index or a clear-all code.

Top module: `dma_err_capture`

## Requirements
- R1: After reset, `stop_o` is 0, the bitmap, status type, status channel and valid bit are all 0, and the fault snapshot is 0.
- R2: A configuration fault (any bit of `cfg_flt` high) or a bus error on a beat that is not a final beat terminates the service at once. It is sampled at clock edge k. After edge k, `stop_o` is high for one cycle and the bitmap bit of the serviced channel is set. The bitmap changes only on such a terminate or on a clear.
- R3: On each terminate, `st_type` is loaded with the error flags and `st_ch` with the failing channel. A later terminate overwrites both. Type bit positions: 0 destination bus error, 1 source bus error, 2..7 copy `cfg_flt[5:0]` (0 descriptor link fault, 1 byte-count fault, 2 destination offset misaligned, 3 destination address misaligned, 4 source offset misaligned, 5 source address misaligned), 8 duplicate channel priority, 9 duplicate group priority.
- R4: `st_vld` is 1 exactly while at least one bitmap bit is set. It stays 1 until the last bit is cleared.
- R5: `flt_saddr`, `flt_daddr` and `flt_cnt` take `cur_saddr`, `cur_daddr` and `cur_cnt` from the cycle the error is detected. In the deferred cases this is the detecting beat, not the terminating beat.
- R6: `done_o` and `irq_o` follow `done_req` and `irq_req`. They are forced to 0 in the cycle an error is detected and while a deferred termination is pending.
- R7: A source bus error on a read beat with `rd_last` set does not stop at once. Termination, with type bit 1, follows the first write beat with `wr_last` set.
- R8: A destination bus error on a write beat with `wr_last` set does not stop at once. Termination, with type bit 0, follows the first read beat with `rd_last` set.
- R9: If any two channels within one group share a priority value when `svc_start` is sampled, the service terminates at that same edge with type bit 8 for channel `act_ch`.
- R10: If any two groups share a priority value when `svc_start` is sampled, the service terminates at that same edge with type bit 9.
- R11: A pulse on `clr_vld` clears bitmap bit `clr_idx[CHW-1:0]`, or every bit when `clr_idx[CHW]` is 1. A terminate in the same cycle for the same channel keeps that bit set.
- R12: A channel with an uncleared error that is serviced again runs and records its error again. Other channels keep being serviced normally afterwards.
- R13: Only the first error of a service is recorded. Errors or faults reported while a deferred termination is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_start | input | 1 | Engine begins servicing `act_ch` |
| act_ch | input | CHW | Channel being started |
| chan_prio | input | NCH*CPW | Per-channel priority within its group |
| grp_prio | input | NGRP*GPW | Per-group priority |
| cfg_flt | input | 6 | Descriptor configuration fault flags |
| rd_beat | input | 1 | A read beat completes this cycle |
| rd_last | input | 1 | Read beat is the final one of its phase |
| src_err | input | 1 | Bus error on the read beat |
| wr_beat | input | 1 | A write beat completes this cycle |
| wr_last | input | 1 | Write beat is the final one of its phase |
| dst_err | input | 1 | Bus error on the write beat |
| cur_saddr | input | AW | Engine's current source address |
| cur_daddr | input | AW | Engine's current destination address |
| cur_cnt | input | CW | Engine's remaining byte count |
| done_req | input | 1 | Engine requests major-loop completion flag |
| irq_req | input | 1 | Engine requests completion interrupt |
| clr_vld | input | 1 | Software clear request |
| clr_idx | input | CHW+1 | Channel to clear; MSB set clears all |
| done_o | output | 1 | Gated completion flag |
| irq_o | output | 1 | Gated completion interrupt |
| stop_o | output | 1 | Terminate pulse for the active service |
| err_map | output | NCH | Sticky per-channel error bitmap |
| st_vld | output | 1 | At least one bitmap bit set |
| st_type | output | 10 | Last error type flags |
| st_ch | output | CHW | Last failing channel |
| flt_saddr | output | AW | Source address at fault |
| flt_daddr | output | AW | Destination address at fault |
| flt_cnt | output | CW | Byte count at fault |

## Verification
Every cycle, the assertions check four things. Each stop pulse leaves the status channel's bitmap bit set, a non-empty type and the valid bit. No bitmap bit rises without a stop pulse. Completion was masked in the detection cycle. Single-channel and clear-all requests take effect. Only the bench's scenarios can show the rest. These are the deferral of final-beat bus errors across the opposite phase, the snapshot being taken at detection and not at termination, the exact type encoding, overwriting by later errors, repeat failure of an uncleared channel, and the priority-duplicate checks.

// File: rtl/dmaerr_pkg.sv
package dmaerr_pkg;
  localparam int ETW = 10;
  localparam int CFW = 6;
  localparam int E_DBE = 0;
  localparam int E_SBE = 1;
  localparam int E_CFG = 2;
  localparam int E_CPE = 8;
  localparam int E_GPE = 9;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_ACTIVE  = 2'd1,
    SQ_DEF_SRC = 2'd2,
    SQ_DEF_DST = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dmaerr_prio_chk.sv
module dmaerr_prio_chk #(
  parameter int NCH  = 16,
  parameter int NGRP = 4,
  parameter int CPW  = 2,
  parameter int GPW  = 2
) (
  input  logic [NCH*CPW-1:0]  chan_prio,
  input  logic [NGRP*GPW-1:0] grp_prio,
  output logic                cpe,
  output logic                gpe
);
  localparam int CPG = NCH / NGRP;

  logic [NGRP-1:0] grp_dup;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_comb begin
        grp_dup[g] = 1'b0;
        for (int i = 0; i < CPG; i++) begin
          for (int j = i + 1; j < CPG; j++) begin
            if (chan_prio[(g*CPG+i)*CPW +: CPW] == chan_prio[(g*CPG+j)*CPW +: CPW])
              grp_dup[g] = 1'b1;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    gpe = 1'b0;
    for (int i = 0; i < NGRP; i++) begin
      for (int j = i + 1; j < NGRP; j++) begin
        if (grp_prio[i*GPW +: GPW] == grp_prio[j*GPW +: GPW])
          gpe = 1'b1;
      end
    end
  end

  assign cpe = |grp_dup;
endmodule

// File: rtl/dmaerr_seq.sv
module dmaerr_seq
  import dmaerr_pkg::*;
#(
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           svc_start,
  input  logic [CHW-1:0] act_ch,
  input  logic           cpe,
  input  logic           gpe,
  input  logic [CFW-1:0] cfg_flt,
  input  logic           rd_beat,
  input  logic           rd_last,
  input  logic           src_err,
  input  logic           wr_beat,
  input  logic           wr_last,
  input  logic           dst_err,
  input  logic           done_req,
  output logic           fire,
  output logic [CHW-1:0] fire_ch,
  output logic [ETW-1:0] fire_type,
  output logic           snap_en,
  output logic           cpl_mask
);
  seq_state_t     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;

  always_comb begin
    state_d   = state_q;
    ch_d      = ch_q;
    fire      = 1'b0;
    snap_en   = 1'b0;
    fire_type = '0;
    case (state_q)
      SQ_IDLE: begin
        if (svc_start) begin
          ch_d = act_ch;
          if (cpe || gpe) begin
            fire             = 1'b1;
            snap_en          = 1'b1;
            fire_type[E_CPE] = cpe;
            fire_type[E_GPE] = gpe;
          end else begin
            state_d = SQ_ACTIVE;
          end
        end
      end
      SQ_ACTIVE: begin
        if (|cfg_flt) begin
          fire                        = 1'b1;
          snap_en                     = 1'b1;
          fire_type[E_CFG +: CFW]     = cfg_flt;
          state_d                     = SQ_IDLE;
        end else if (rd_beat && src_err) begin
          snap_en = 1'b1;
          if (rd_last) begin
            state_d = SQ_DEF_SRC;
          end else begin
            fire             = 1'b1;
            fire_type[E_SBE] = 1'b1;
            state_d          = SQ_IDLE;
          end
        end else if (wr_beat && dst_err) begin
          snap_en = 1'b1;
          if (wr_last) begin
            state_d = SQ_DEF_DST;
          end else begin
            fire             = 1'b1;
            fire_type[E_DBE] = 1'b1;
            state_d          = SQ_IDLE;
          end
        end else if (done_req) begin
          state_d = SQ_IDLE;
        end
      end
      SQ_DEF_SRC: begin
        if (wr_beat && wr_last) begin
          fire             = 1'b1;
          fire_type[E_SBE] = 1'b1;
          state_d          = SQ_IDLE;
        end
      end
      SQ_DEF_DST: begin
        if (rd_beat && rd_last) begin
          fire             = 1'b1;
          fire_type[E_DBE] = 1'b1;
          state_d          = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign fire_ch  = (state_q == SQ_IDLE) ? act_ch : ch_q;
  assign cpl_mask = snap_en || (state_q == SQ_DEF_SRC) || (state_q == SQ_DEF_DST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end
endmodule

// File: rtl/dmaerr_rec.sv
module dmaerr_rec
  import dmaerr_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CHW = 4,
  parameter int AW  = 32,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [CHW-1:0] fire_ch,
  input  logic [ETW-1:0] fire_type,
  input  logic           snap_en,
  input  logic [AW-1:0]  cur_saddr,
  input  logic [AW-1:0]  cur_daddr,
  input  logic [CW-1:0]  cur_cnt,
  input  logic           clr_vld,
  input  logic [CHW:0]   clr_idx,
  output logic           stop_o,
  output logic [NCH-1:0] err_map,
  output logic           st_vld,
  output logic [ETW-1:0] st_type,
  output logic [CHW-1:0] st_ch,
  output logic [AW-1:0]  flt_saddr,
  output logic [AW-1:0]  flt_daddr,
  output logic [CW-1:0]  flt_cnt
);
  logic [NCH-1:0] clr_mask, set_mask, map_d;
  logic           map_en;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      clr_mask[i] = clr_vld && (clr_idx[CHW] || (clr_idx[CHW-1:0] == CHW'(i)));
      set_mask[i] = fire && (fire_ch == CHW'(i));
    end
    map_en = clr_vld || fire;
    map_d  = (err_map & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_map <= '0;
    end else if (map_en) begin
      err_map <= map_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_o <= 1'b0;
    end else begin
      stop_o <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_type <= '0;
      st_ch   <= '0;
    end else if (fire) begin
      st_type <= fire_type;
      st_ch   <= fire_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_saddr <= '0;
      flt_daddr <= '0;
      flt_cnt   <= '0;
    end else if (snap_en) begin
      flt_saddr <= cur_saddr;
      flt_daddr <= cur_daddr;
      flt_cnt   <= cur_cnt;
    end
  end

  assign st_vld = |err_map;
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dmaerr_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NGRP = 4,
  parameter int AW   = 32,
  parameter int CW   = 16,
  localparam int CHW = $clog2(NCH),
  localparam int CPW = (NCH / NGRP > 1) ? $clog2(NCH / NGRP) : 1,
  localparam int GPW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                svc_start,
  input  logic [CHW-1:0]      act_ch,
  input  logic [NCH*CPW-1:0]  chan_prio,
  input  logic [NGRP*GPW-1:0] grp_prio,
  input  logic [5:0]          cfg_flt,
  input  logic                rd_beat,
  input  logic                rd_last,
  input  logic                src_err,
  input  logic                wr_beat,
  input  logic                wr_last,
  input  logic                dst_err,
  input  logic [AW-1:0]       cur_saddr,
  input  logic [AW-1:0]       cur_daddr,
  input  logic [CW-1:0]       cur_cnt,
  input  logic                done_req,
  input  logic                irq_req,
  input  logic                clr_vld,
  input  logic [CHW:0]        clr_idx,
  output logic                done_o,
  output logic                irq_o,
  output logic                stop_o,
  output logic [NCH-1:0]      err_map,
  output logic                st_vld,
  output logic [9:0]          st_type,
  output logic [CHW-1:0]      st_ch,
  output logic [AW-1:0]       flt_saddr,
  output logic [AW-1:0]       flt_daddr,
  output logic [CW-1:0]       flt_cnt
);
  logic           cpe, gpe;
  logic           fire, snap_en, cpl_mask;
  logic [CHW-1:0] fire_ch;
  logic [ETW-1:0] fire_type;

  dmaerr_prio_chk #(
    .NCH(NCH), .NGRP(NGRP), .CPW(CPW), .GPW(GPW)
  ) u_prio (
    .chan_prio (chan_prio),
    .grp_prio  (grp_prio),
    .cpe       (cpe),
    .gpe       (gpe)
  );

  dmaerr_seq #(.CHW(CHW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_start (svc_start),
    .act_ch    (act_ch),
    .cpe       (cpe),
    .gpe       (gpe),
    .cfg_flt   (cfg_flt),
    .rd_beat   (rd_beat),
    .rd_last   (rd_last),
    .src_err   (src_err),
    .wr_beat   (wr_beat),
    .wr_last   (wr_last),
    .dst_err   (dst_err),
    .done_req  (done_req),
    .fire      (fire),
    .fire_ch   (fire_ch),
    .fire_type (fire_type),
    .snap_en   (snap_en),
    .cpl_mask  (cpl_mask)
  );

  dmaerr_rec #(.NCH(NCH), .CHW(CHW), .AW(AW), .CW(CW)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .fire_ch   (fire_ch),
    .fire_type (fire_type),
    .snap_en   (snap_en),
    .cur_saddr (cur_saddr),
    .cur_daddr (cur_daddr),
    .cur_cnt   (cur_cnt),
    .clr_vld   (clr_vld),
    .clr_idx   (clr_idx),
    .stop_o    (stop_o),
    .err_map   (err_map),
    .st_vld    (st_vld),
    .st_type   (st_type),
    .st_ch     (st_ch),
    .flt_saddr (flt_saddr),
    .flt_daddr (flt_daddr),
    .flt_cnt   (flt_cnt)
  );

  assign done_o = done_req && !cpl_mask;
  assign irq_o  = irq_req && !cpl_mask;
endmodule

// File: rtl/dmaerr_chk.sv
module dmaerr_chk #(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           stop_o,
  input logic [NCH-1:0] err_map,
  input logic           st_vld,
  input logic [9:0]     st_type,
  input logic [CHW-1:0] st_ch,
  input logic           done_o,
  input logic           irq_o,
  input logic           clr_vld,
  input logic [CHW:0]   clr_idx,
  input logic           fire,
  input logic [CHW-1:0] fire_ch
);
  // R2
  map_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> err_map[st_ch]);

  // R2
  map_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_map & ~$past(err_map))) |-> stop_o);

  // R3
  type_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (st_type != 10'd0));

  // R4
  vld_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> st_vld);

  // R6
  cpl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!$past(done_o) && !$past(irq_o)));

  // R11
  clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !clr_idx[CHW] && !(fire && fire_ch == clr_idx[CHW-1:0]))
      |=> !err_map[$past(clr_idx[CHW-1:0])]);

  // R11
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && clr_idx[CHW] && !fire) |=> (err_map == '0));
endmodule

bind dma_err_capture dmaerr_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop_o  (stop_o),
  .err_map (err_map),
  .st_vld  (st_vld),
  .st_type (st_type),
  .st_ch   (st_ch),
  .done_o  (done_o),
  .irq_o   (irq_o),
  .clr_vld (clr_vld),
  .clr_idx (clr_idx),
  .fire    (fire),
  .fire_ch (fire_ch)
);

// File: tb/dma_err_capture_test.sv
`timescale 1ns/1ps
module dma_err_capture_test;
  localparam int NCH = 16, NGRP = 4, AW = 32, CW = 16;
  localparam int CHW = 4, CPW = 2, GPW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic svc_start, rd_beat, rd_last, src_err, wr_beat, wr_last, dst_err;
  logic done_req, irq_req, clr_vld;
  logic [CHW-1:0] act_ch;
  logic [NCH*CPW-1:0] chan_prio;
  logic [NGRP*GPW-1:0] grp_prio;
  logic [5:0] cfg_flt;
  logic [AW-1:0] cur_saddr, cur_daddr;
  logic [CW-1:0] cur_cnt;
  logic [CHW:0] clr_idx;
  logic done_o, irq_o, stop_o, st_vld;
  logic [NCH-1:0] err_map;
  logic [9:0] st_type;
  logic [CHW-1:0] st_ch;
  logic [AW-1:0] flt_saddr, flt_daddr;
  logic [CW-1:0] flt_cnt;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [NCH-1:0] m_map;
  logic [9:0] m_type;
  logic [CHW-1:0] m_ch;
  logic [AW-1:0] m_sa, m_da;
  logic [CW-1:0] m_cnt;

  always #4 clk = ~clk;

  dma_err_capture uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    svc_start = 0; rd_beat = 0; rd_last = 0; src_err = 0;
    wr_beat = 0; wr_last = 0; dst_err = 0; done_req = 0; irq_req = 0;
    cfg_flt = 0; clr_vld = 0; clr_idx = 0;
  endtask

  task automatic prio_ok();
    for (int i = 0; i < NCH; i++) chan_prio[i*CPW +: CPW] = CPW'(i % (NCH/NGRP));
    for (int g = 0; g < NGRP; g++) grp_prio[g*GPW +: GPW] = GPW'(g);
  endtask

  function automatic logic [9:0] cfg_type(input logic [5:0] cf);
    return {2'b00, cf, 2'b00};
  endfunction

  task automatic check_state(input string req);
    chk(err_map == m_map, req, err_map, m_map);
    chk(st_vld == (m_map != 0), "R4", st_vld, m_map != 0);
  endtask

  // called one negedge after the terminating edge
  task automatic check_fire(input int ch, input logic [9:0] ty, input logic [AW-1:0] sa,
                            input logic [AW-1:0] da, input logic [CW-1:0] cnt, input string req);
    m_map[ch] = 1'b1; m_type = ty; m_ch = CHW'(ch); m_sa = sa; m_da = da; m_cnt = cnt;
    chk(stop_o == 1'b1, req, stop_o, 1);
    check_state(req);
    chk(st_type == m_type, "R3", st_type, m_type);
    chk(st_ch == m_ch, "R3", st_ch, m_ch);
    chk(flt_saddr == m_sa, "R5", flt_saddr, m_sa);
    chk(flt_daddr == m_da, "R5", flt_daddr, m_da);
    chk(flt_cnt == m_cnt, "R5", flt_cnt, m_cnt);
  endtask

  task automatic do_clr(input logic [CHW:0] idx);
    clr_vld = 1; clr_idx = idx;
    @(negedge clk);
    clr_vld = 0;
    if (idx[CHW]) m_map = '0; else m_map[idx[CHW-1:0]] = 1'b0;
    check_state("R11");
  endtask

  // kind: 0 clean, 1 cfg fault, 2 src err mid, 3 dst err mid, 4 src err final, 5 dst err final
  task automatic svc(input int ch, input int kind, input bit coll);
    logic [AW-1:0] sa, da; logic [CW-1:0] cnt; logic [5:0] cf;
    sa = $urandom; da = $urandom; cnt = CW'($urandom); cf = 6'($urandom_range(1, 63));
    act_ch = CHW'(ch); svc_start = 1;
    @(negedge clk);
    svc_start = 0;
    chk(stop_o == 0, "R2", stop_o, 0);
    cur_saddr = sa; cur_daddr = da; cur_cnt = cnt;
    case (kind)
      0: begin
        done_req = 1; irq_req = 1; #1;
        chk(done_o && irq_o, "R6", {done_o, irq_o}, 2'b11);
        @(negedge clk); idle_in();
        chk(stop_o == 0, "R12", stop_o, 0);
        check_state("R12");
      end
      1, 2, 3: begin
        if (kind == 1) cfg_flt = cf;
        if (kind == 2) begin rd_beat = 1; src_err = 1; end
        if (kind == 3) begin wr_beat = 1; dst_err = 1; end
        if (coll) begin clr_vld = 1; clr_idx = {1'b0, CHW'(ch)}; end
        done_req = 1; irq_req = 1; #1;
        chk(!done_o && !irq_o, "R6", {done_o, irq_o}, 0);
        @(negedge clk); idle_in();
        check_fire(ch, (kind == 1) ? cfg_type(cf) : (kind == 2) ? 10'b10 : 10'b01, sa, da, cnt,
                   coll ? "R11" : "R2");
      end
      default: begin
        if (kind == 4) begin rd_beat = 1; rd_last = 1; src_err = 1; end
        else begin wr_beat = 1; wr_last = 1; dst_err = 1; end
        @(negedge clk); idle_in();
        chk(stop_o == 0, (kind == 4) ? "R7" : "R8", stop_o, 0);
        chk(flt_saddr == sa, "R5", flt_saddr, sa);
        cur_saddr = ~sa; cur_daddr = ~da; cur_cnt = ~cnt;
        if (kind == 4) begin wr_beat = 1; dst_err = 1; end
        else begin rd_beat = 1; src_err = 1; end
        cfg_flt = cf; done_req = 1; irq_req = 1; #1;
        chk(!done_o && !irq_o, "R6", {done_o, irq_o}, 0);
        @(negedge clk); idle_in();
        chk(stop_o == 0, "R13", stop_o, 0);
        if (kind == 4) begin wr_beat = 1; wr_last = 1; end
        else begin rd_beat = 1; rd_last = 1; end
        @(negedge clk); idle_in();
        check_fire(ch, (kind == 4) ? 10'b10 : 10'b01, sa, da, cnt, (kind == 4) ? "R7" : "R8");
      end
    endcase
  endtask

  task automatic prio_fail(input int ch, input bit grp);
    prio_ok();
    if (grp) grp_prio[3*GPW +: GPW] = grp_prio[1*GPW +: GPW];
    else chan_prio[9*CPW +: CPW] = chan_prio[10*CPW +: CPW];
    cur_saddr = $urandom; cur_daddr = $urandom; cur_cnt = CW'($urandom);
    act_ch = CHW'(ch); svc_start = 1;
    @(negedge clk); idle_in();
    check_fire(ch, grp ? 10'h200 : 10'h100, cur_saddr, cur_daddr, cur_cnt, grp ? "R10" : "R9");
    prio_ok();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    idle_in(); prio_ok(); act_ch = 0;
    cur_saddr = 0; cur_daddr = 0; cur_cnt = 0;
    m_map = 0; m_type = 0; m_ch = 0; m_sa = 0; m_da = 0; m_cnt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(stop_o == 0 && st_vld == 0, "R1", {stop_o, st_vld}, 0);
    chk(err_map == 0 && st_type == 0 && st_ch == 0, "R1", {err_map, st_type, st_ch}, 0);
    chk(flt_saddr == 0 && flt_daddr == 0 && flt_cnt == 0, "R1", flt_saddr, 0);

    // directed corners
    svc(3, 1, 0);                         // R2 cfg fault
    svc(7, 2, 0);                         // R3 overwrite by later error
    svc(7, 2, 0);                         // R12 repeat without clear
    svc(8, 0, 0);                         // R12 other channel proceeds
    do_clr({1'b0, 4'd3});                 // R4 valid stays with bit 7
    chk(st_vld == 1, "R4", st_vld, 1);
    do_clr({1'b0, 4'd7});
    chk(st_vld == 0, "R4", st_vld, 0);
    svc(5, 4, 0);                         // R7 deferred source error
    svc(6, 5, 0);                         // R8 deferred destination error
    svc(12, 1, 1);                        // R11 set wins over clear
    prio_fail(2, 0);                      // R9
    prio_fail(14, 1);                     // R10
    do_clr({1'b1, 4'd0});                 // R11 clear all

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 5);
      svc($urandom_range(0, NCH - 1), k, (k == 1) && ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 3) == 0)
        do_clr({1'($urandom_range(0, 7) == 0), CHW'($urandom_range(0, NCH - 1))});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule